// File: doc/BRIEF.md
# Dual Reference Clock Guard

The block sits in the fast oscillator clock domain of a clock generator and watches two reference inputs that have already been sampled into that domain. For each reference it counts the cycles since the sampled level last changed. A reference that stays at one level for too long is flagged as failed, and the guard then moves the loop onto the other reference if that one is still healthy.

Recovery is handled in one of two ways. In revertive operation a flag drops as soon as its reference moves again, and the configured default reference is taken back. In latched operation a flag stays up until the guard is cleared. When both references are gone and holdover is permitted, the guard reports holdover so that the loop can freeze its control value. Software can also force holdover directly. A status byte gathers the two failure flags, the reference in use and the holdover state at fixed bit positions that the register file decodes.

Top module: `refclk_guard`

## Requirements
- R1: While `rst` is high, and on the first rising clock edge after it is applied, the guard clears both failure flags and holdover, and `sel_o` takes the value of `dflt_i`.
- R2: If the sampled level of a reference stays the same on LOSS_CYC consecutive rising edges (default 2) after the edge where it last changed, its failure flag rises on the next edge. A reference that toggles on every edge never fails.
- R3: `stat_o` bit 6 is the flag for reference 0, bit 5 is the flag for reference 1, bit 4 equals `sel_o`, bit 2 is holdover, and all other bits are 0. `irq_o` is the OR of the two flags.
- R4: When the selected reference fails while the other is not flagged, `sel_o` changes to the other reference on the same edge that raises the flag.
- R5: With `revert_i` high, a flag clears on the edge after its reference moves again. If that reference is the default, or the other reference is still flagged, it is selected again. If both clear on the same edge, the default is selected.
- R6: With `revert_i` low, a raised flag and `irq_o` stay high until the guard is cleared or the monitor becomes inactive.
- R7: A low-to-high change on `mon_off_i`, `sw_rst_i` or `mon_rst_i` clears both flags and the miss counters, and selects `dflt_i`, on that edge.
- R8: With `hold_en_i` high and the monitor active, holdover is reported while both flags are set. With `hold_en_i` and `hold_force_i` both low, holdover is never reported.
- R9: `hold_force_i` high reports holdover from the next edge on. Lowering it ends holdover unless the condition in R8 holds.
- R10: In revertive holdover, recovery of one reference ends holdover and selects that reference. Recovery of both on the same edge selects the default.
- R11: The enabled set is taken from `pin_en_i` when `en_ovr_i` is 00. Otherwise it is `en_ovr_i` itself, with bit 0 for reference 0 and bit 1 for reference 1. Unless both are enabled and `mon_off_i` is low, the monitor is inactive: flags stay clear, and if exactly one reference is enabled, that reference is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous master reset, active high |
| ref_i | input | 2 | Sampled reference levels, bit n for reference n |
| pin_en_i | input | 2 | Reference enables from pins |
| en_ovr_i | input | 2 | Register enable field, 00 means use pins |
| dflt_i | input | 1 | Default reference |
| revert_i | input | 1 | Revertive recovery when high |
| hold_en_i | input | 1 | Permit automatic holdover |
| hold_force_i | input | 1 | Force holdover |
| mon_off_i | input | 1 | Monitor disable; rising edge clears the guard |
| sw_rst_i | input | 1 | Software reset bit; rising edge clears the guard |
| mon_rst_i | input | 1 | Monitor clear bit; rising edge clears the guard |
| sel_o | output | 1 | Reference in use |
| irq_o | output | 1 | Failure interrupt |
| stat_o | output | 8 | Status byte (fail0 bit 6, fail1 bit 5, in-use bit 4, holdover bit 2) |

## Verification
A wrong miss count would show at the ports as a flag that rises one or more edges too early or too late, or that rises on a reference that keeps toggling. The edge on which a flag appears is fixed exactly by the stimulus. A wrong selection or holdover decision shows up on `sel_o` or bit 2 of `stat_o` on the same edge as the flag change that caused it. Because of that, a model that is compared on every cycle catches a fault within one clock of its cause. Latched flags that fail to clear would persist across a clear pulse and show up on the very next cycle.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;

    localparam int NREF     = 2;
    localparam int ST_FAIL0 = 6;
    localparam int ST_FAIL1 = 5;
    localparam int ST_INUSE = 4;
    localparam int ST_HOLD  = 2;
    localparam int ST_W     = 8;
    localparam int NCLR     = 3;

    typedef struct packed {
        logic [NREF-1:0] fail;
        logic            sel;
        logic            hold;
    } guard_state_t;

    function automatic logic [NREF-1:0] pick_enables(input logic [NREF-1:0] ovr,
                                                     input logic [NREF-1:0] pins);
        return (ovr == '0) ? pins : ovr;
    endfunction

    function automatic logic [ST_W-1:0] pack_status(input guard_state_t s);
        logic [ST_W-1:0] b;
        b           = '0;
        b[ST_FAIL0] = s.fail[0];
        b[ST_FAIL1] = s.fail[1];
        b[ST_INUSE] = s.sel;
        b[ST_HOLD]  = s.hold;
        return b;
    endfunction

endpackage

// File: rtl/refclk_guard_watch.sv
module refclk_guard_watch #(
    parameter int LOSS_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic smp,
    output logic dead
);
    localparam int CW = $clog2(LOSS_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

    logic          prev_q;
    logic [CW-1:0] miss_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= smp;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)          miss_q <= '0;
        else if (smp != prev_q)  miss_q <= '0;
        else if (miss_q != LIMIT) miss_q <= miss_q + 1'b1;
    end

    assign dead = (miss_q == LIMIT);
endmodule

// File: rtl/refclk_guard_evt.sv
module refclk_guard_evt #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    output logic            evt
);
    logic [NSRC-1:0] rise;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic last_q;
        always_ff @(posedge clk) begin
            last_q <= src[g];
        end
        assign rise[g] = src[g] & ~last_q & ~rst;
    end

    assign evt = |rise;
endmodule

// File: rtl/refclk_guard_core.sv
module refclk_guard_core
    import refclk_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NREF-1:0] dead,
    input  logic [NREF-1:0] en,
    input  logic            mon_off,
    input  logic            evt,
    input  logic            dflt,
    input  logic            revert,
    input  logic            hold_en,
    input  logic            hold_force,
    output guard_state_t    st
);
    guard_state_t    st_q;
    logic [NREF-1:0] f_n;
    logic [NREF-1:0] rec;
    logic            sel_n;
    logic            hold_n;
    logic            mon_act;

    assign mon_act = (en == '1) && !mon_off;

    always_comb begin
        f_n   = st_q.fail;
        sel_n = st_q.sel;
        rec   = '0;
        if (evt) begin
            f_n   = '0;
            sel_n = dflt;
        end else if (!mon_act) begin
            f_n = '0;
            if (en == 2'b01)      sel_n = 1'b0;
            else if (en == 2'b10) sel_n = 1'b1;
        end else begin
            for (int i = 0; i < NREF; i++) begin
                if (dead[i])     f_n[i] = 1'b1;
                else if (revert) f_n[i] = 1'b0;
            end
            rec = st_q.fail & ~f_n;
            if (rec == 2'b11)                      sel_n = dflt;
            else if (rec[0] && (!dflt || f_n[1]))  sel_n = 1'b0;
            else if (rec[1] && (dflt || f_n[0]))   sel_n = 1'b1;
            else if (f_n[st_q.sel] && !f_n[~st_q.sel]) sel_n = ~st_q.sel;
        end
        hold_n = hold_force | (hold_en & mon_act & (&f_n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fail <= '0;
            st_q.sel  <= dflt;
            st_q.hold <= 1'b0;
        end else begin
            st_q.fail <= f_n;
            st_q.sel  <= sel_n;
            st_q.hold <= hold_n;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
    import refclk_guard_pkg::*;
#(
    parameter int LOSS_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ref_i,
    input  logic [1:0] pin_en_i,
    input  logic [1:0] en_ovr_i,
    input  logic       dflt_i,
    input  logic       revert_i,
    input  logic       hold_en_i,
    input  logic       hold_force_i,
    input  logic       mon_off_i,
    input  logic       sw_rst_i,
    input  logic       mon_rst_i,
    output logic       sel_o,
    output logic       irq_o,
    output logic [7:0] stat_o
);
    logic [NREF-1:0] dead;
    logic [NREF-1:0] en;
    logic            clr_evt;
    guard_state_t    st;

    refclk_guard_evt #(.NSRC(NCLR)) u_evt (
        .clk (clk),
        .rst (rst),
        .src ({mon_rst_i, sw_rst_i, mon_off_i}),
        .evt (clr_evt)
    );

    for (genvar g = 0; g < NREF; g++) begin : g_watch
        refclk_guard_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_evt),
            .smp  (ref_i[g]),
            .dead (dead[g])
        );
    end

    assign en = pick_enables(en_ovr_i, pin_en_i);

    refclk_guard_core u_core (
        .clk        (clk),
        .rst        (rst),
        .dead       (dead),
        .en         (en),
        .mon_off    (mon_off_i),
        .evt        (clr_evt),
        .dflt       (dflt_i),
        .revert     (revert_i),
        .hold_en    (hold_en_i),
        .hold_force (hold_force_i),
        .st         (st)
    );

    assign sel_o  = st.sel;
    assign irq_o  = |st.fail;
    assign stat_o = pack_status(st);
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk
    import refclk_guard_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] pin_en_i,
    input logic [1:0] en_ovr_i,
    input logic       dflt_i,
    input logic       revert_i,
    input logic       hold_en_i,
    input logic       hold_force_i,
    input logic       mon_off_i,
    input logic       sw_rst_i,
    input logic       mon_rst_i,
    input logic       sel_o,
    input logic       irq_o,
    input logic [7:0] stat_o
);
    logic mon_ok;
    assign mon_ok = (pick_enables(en_ovr_i, pin_en_i) == 2'b11) && !mon_off_i;

    assert_status_map_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_o == (stat_o[6] | stat_o[5])) && (stat_o[4] == sel_o) &&
        (stat_o[7] == 1'b0) && (stat_o[3] == 1'b0) && (stat_o[1:0] == 2'b00));

    assert_latched_R6: assert property (@(posedge clk) disable iff (rst)
        (!revert_i && stat_o[6] && mon_ok && !$rose(sw_rst_i) && !$rose(mon_rst_i))
        |=> stat_o[6]);

    assert_clear_sel_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_rst_i) |=> (sel_o == $past(dflt_i)) && !irq_o);

    assert_no_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!hold_en_i && !hold_force_i) |=> !stat_o[2]);

    assert_auto_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (hold_en_i && mon_ok && !revert_i && stat_o[6] && stat_o[5] &&
         !$rose(sw_rst_i) && !$rose(mon_rst_i)) |=> stat_o[2]);

    assert_force_hold_R9: assert property (@(posedge clk) disable iff (rst)
        hold_force_i |=> stat_o[2]);

    assert_inactive_R11: assert property (@(posedge clk) disable iff (rst)
        !mon_ok |=> !irq_o);
endmodule

bind refclk_guard refclk_guard_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .pin_en_i     (pin_en_i),
    .en_ovr_i     (en_ovr_i),
    .dflt_i       (dflt_i),
    .revert_i     (revert_i),
    .hold_en_i    (hold_en_i),
    .hold_force_i (hold_force_i),
    .mon_off_i    (mon_off_i),
    .sw_rst_i     (sw_rst_i),
    .mon_rst_i    (mon_rst_i),
    .sel_o        (sel_o),
    .irq_o        (irq_o),
    .stat_o       (stat_o)
);

// File: tb/test_refclk_guard.sv
`timescale 1ns/1ps
module test_refclk_guard;
    localparam int LOSS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_i = 2'b00;
    logic [1:0] pin_en_i = 2'b11;
    logic [1:0] en_ovr_i = 2'b00;
    logic       dflt_i = 1'b0;
    logic       revert_i = 1'b1;
    logic       hold_en_i = 1'b1;
    logic       hold_force_i = 1'b0;
    logic       mon_off_i = 1'b0;
    logic       sw_rst_i = 1'b0;
    logic       mon_rst_i = 1'b0;
    logic       sel_o, irq_o;
    logic [7:0] stat_o;

    logic [1:0] run = 2'b11;
    string      cur_req = "R1";
    int         n_chk = 0;
    int         n_fail = 0;
    bit         started = 0;

    // behavioural reference state
    int m_f0, m_f1, m_sel, m_hold;
    int m_cnt[2];
    int m_prev[2];
    int m_last[3];

    always #2.5 clk = ~clk;

    refclk_guard #(.LOSS_CYC(LOSS)) i_refclk_guard (
        .clk(clk), .rst(rst), .ref_i(ref_i), .pin_en_i(pin_en_i), .en_ovr_i(en_ovr_i),
        .dflt_i(dflt_i), .revert_i(revert_i), .hold_en_i(hold_en_i),
        .hold_force_i(hold_force_i), .mon_off_i(mon_off_i), .sw_rst_i(sw_rst_i),
        .mon_rst_i(mon_rst_i), .sel_o(sel_o), .irq_o(irq_o), .stat_o(stat_o)
    );

    always @(posedge clk) begin
        int srcs[3];
        int dead[2];
        int clr, ena, act, n0, n1, r0, r1, ns;
        srcs[0] = mon_off_i; srcs[1] = sw_rst_i; srcs[2] = mon_rst_i;
        started = 1;
        if (rst) begin
            m_f0 = 0; m_f1 = 0; m_hold = 0; m_sel = dflt_i;
            for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_prev[i] = 0; end
            for (int k = 0; k < 3; k++) m_last[k] = srcs[k];
        end else begin
            clr = 0;
            for (int k = 0; k < 3; k++) begin
                if (srcs[k] == 1 && m_last[k] == 0) clr = 1;
                m_last[k] = srcs[k];
            end
            for (int i = 0; i < 2; i++) begin
                dead[i] = (m_cnt[i] >= LOSS);
                if (clr || ref_i[i] != m_prev[i]) m_cnt[i] = 0;
                else if (m_cnt[i] < LOSS) m_cnt[i]++;
                m_prev[i] = ref_i[i];
            end
            ena = (en_ovr_i == 0) ? pin_en_i : en_ovr_i;
            act = (ena == 3) && !mon_off_i;
            n0 = m_f0; n1 = m_f1; ns = m_sel;
            if (clr) begin n0 = 0; n1 = 0; ns = dflt_i; end
            else if (!act) begin
                n0 = 0; n1 = 0;
                if (ena == 1) ns = 0; else if (ena == 2) ns = 1;
            end else begin
                n0 = dead[0] ? 1 : (revert_i ? 0 : m_f0);
                n1 = dead[1] ? 1 : (revert_i ? 0 : m_f1);
                r0 = m_f0 && !n0; r1 = m_f1 && !n1;
                if (r0 && r1) ns = dflt_i;
                else if (r0 && (dflt_i == 0 || n1)) ns = 0;
                else if (r1 && (dflt_i == 1 || n0)) ns = 1;
                else if (m_sel == 0 && n0 && !n1) ns = 1;
                else if (m_sel == 1 && n1 && !n0) ns = 0;
            end
            m_hold = hold_force_i || (hold_en_i && act && n0 && n1);
            m_f0 = n0; m_f1 = n1; m_sel = ns;
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(cur_req, "sel_o", sel_o, m_sel);
            check(cur_req, "irq_o", irq_o, (m_f0 || m_f1));
            check(cur_req, "stat_o", stat_o,
                  (m_f0 << 6) | (m_f1 << 5) | (m_sel << 4) | (m_hold << 2));
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            for (int i = 0; i < 2; i++) if (run[i]) ref_i[i] = ~ref_i[i];
        end
    endtask

    task automatic pulse_clr(input int which);
        if (which == 0) sw_rst_i = 1'b1; else if (which == 1) mon_rst_i = 1'b1; else mon_off_i = 1'b1;
        cyc(1);
        sw_rst_i = 1'b0; mon_rst_i = 1'b0; mon_off_i = 1'b0;
        cyc(3);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cur_req = "R1"; cyc(3);
        rst = 1'b0; cyc(1);
        check("R1", "sel after reset", sel_o, 0);
        check("R1", "stat after reset", stat_o, 0);
        cyc(3);
        // R2, R4: reference 0 stops while selected
        cur_req = "R4"; run = 2'b10; cyc(6);
        check("R4", "switched to ref1", sel_o, 1);
        check("R2", "fail0 bit", stat_o[6], 1);
        // R5: revertive recovery reselects default
        cur_req = "R5"; run = 2'b11; cyc(5);
        check("R5", "back to default", sel_o, 0);
        check("R5", "irq cleared", irq_o, 0);
        // R2: unselected reference fails, no switch
        cur_req = "R2"; run = 2'b01; cyc(6); run = 2'b11; cyc(4);
        // R8/R10: both fail, holdover, single recovery
        cur_req = "R8"; run = 2'b00; cyc(6);
        check("R8", "holdover", stat_o[2], 1);
        cur_req = "R10"; run = 2'b10; cyc(5);
        check("R10", "ref1 after holdover", sel_o, 1);
        check("R10", "holdover left", stat_o[2], 0);
        run = 2'b11; cyc(5);
        dflt_i = 1'b1; cur_req = "R10"; run = 2'b00; cyc(6); run = 2'b11; cyc(5);
        check("R10", "default after joint recovery", sel_o, 1);
        dflt_i = 1'b0;
        // R8 negative: holdover disabled
        cur_req = "R8"; hold_en_i = 1'b0; run = 2'b00; cyc(6);
        check("R8", "no holdover when disabled", stat_o[2], 0);
        run = 2'b11; cyc(5); hold_en_i = 1'b1;
        // R6: latched failures
        cur_req = "R6"; revert_i = 1'b0; run = 2'b10; cyc(6); run = 2'b11; cyc(6);
        check("R6", "fail0 latched", stat_o[6], 1);
        // R7: each clear source
        cur_req = "R7"; pulse_clr(0);
        check("R7", "sw clear", stat_o[6], 0);
        run = 2'b10; cyc(6); run = 2'b11; cyc(3); pulse_clr(1);
        check("R7", "monitor clear bit", irq_o, 0);
        run = 2'b01; cyc(6); run = 2'b11; cyc(3); pulse_clr(2);
        check("R7", "monitor pin edge", irq_o, 0);
        run = 2'b10; cyc(6); run = 2'b11;
        cur_req = "R1"; rst = 1'b1; cyc(2); rst = 1'b0; cyc(3);
        check("R1", "master reset clears", stat_o, 0);
        revert_i = 1'b1;
        // R9: forced holdover
        cur_req = "R9"; hold_force_i = 1'b1; cyc(3);
        check("R9", "forced holdover", stat_o[2], 1);
        hold_force_i = 1'b0; cyc(3);
        check("R9", "forced holdover released", stat_o[2], 0);
        // R11: enable decoding and inactive monitor
        cur_req = "R11"; en_ovr_i = 2'b10; run = 2'b00; cyc(6);
        check("R11", "only ref1 enabled", sel_o, 1);
        check("R11", "no failure while inactive", irq_o, 0);
        en_ovr_i = 2'b01; cyc(3);
        check("R11", "only ref0 enabled", sel_o, 0);
        en_ovr_i = 2'b00; pin_en_i = 2'b10; cyc(3);
        check("R11", "pins select ref1", sel_o, 1);
        pin_en_i = 2'b11; mon_off_i = 1'b1; cyc(6);
        check("R11", "monitor off", irq_o, 0);
        mon_off_i = 1'b0; run = 2'b11; cyc(6);
        cur_req = "R3"; run = 2'b01; cyc(6); run = 2'b11; cyc(4);
        summary();
    end
endmodule